// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute stage of a load/store processor core. Each issued operation carries a 4-bit opcode, two 32-bit operands (the second already passed through the shifter), the shifter's carry-out, the current N, Z, C and V flags, and a set-flags bit. One clock edge later the block presents the result, a write strobe for the destination register, and the flag values the core should adopt next.

All sixteen data-processing operations share one adder and one bitwise unit. Subtractions are built by inverting one operand and choosing the carry-in. The reverse forms swap which operand is inverted. The carry-based forms feed the current C flag into the adder. Four operations are test-only: they update flags and never raise the write strobe. When the first operand is the program counter, an operand-select stage adds the pipeline look-ahead to the instruction address before the arithmetic.

Top module: `alu_core`

## Requirements
- R1: Opcode encoding is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The logical results are a&b (AND, TST), a^b (EOR, TEQ), a|b (ORR), b (MOV), a&~b (BIC) and ~b (MVN).
- R2: SUB and CMP give a−b, RSB gives b−a, and ADD and CMN give a+b, all modulo 2^32.
- R3: ADC gives a+b+C. SBC gives a−b−(1−C). RSC gives b−a−(1−C). C is the flag_c_in input.
- R4: result_we is 1 one cycle after an accepted operation whose opcode is not 8 to 11. It is 0 after opcodes 8 to 11, and 0 after any cycle with op_valid low.
- R5: With set_flags=1 on an arithmetic opcode (2 to 7, 10, 11), C is the adder carry-out, which means "no borrow" for subtraction. V is set when signed overflow occurs.
- R6: With set_flags=1 on a logical opcode (0, 1, 8, 9, 12 to 15), C takes shift_carry and V keeps flag_v_in.
- R7: With set_flags=1, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero. This includes the test-only opcodes.
- R8: With set_flags=0, the four flag outputs equal the four flag inputs.
- R9: When op_a_is_pc=1, operand a is inst_addr+8, or inst_addr+12 when shift_by_reg=1. Otherwise it is operand_a.
- R10: Outputs are registered with one cycle of latency. During reset the result, the write strobe and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| opcode | input | 4 | Operation code (R1) |
| set_flags | input | 1 | Update flags from the result |
| operand_a | input | 32 | First operand from register read |
| operand_b | input | 32 | Second operand, already shifted |
| op_a_is_pc | input | 1 | First operand is the program counter |
| shift_by_reg | input | 1 | Second operand was shifted by a register amount |
| inst_addr | input | 32 | Address of the executing instruction |
| shift_carry | input | 1 | Shifter carry-out |
| flag_n_in | input | 1 | Current N |
| flag_z_in | input | 1 | Current Z |
| flag_c_in | input | 1 | Current C |
| flag_v_in | input | 1 | Current V |
| result | output | 32 | Operation result |
| result_we | output | 1 | Destination write strobe |
| flag_n | output | 1 | Next N |
| flag_z | output | 1 | Next Z |
| flag_c | output | 1 | Next C |
| flag_v | output | 1 | Next V |

## Verification
Random operands with random opcodes, flag inputs and set-flags bits cover all sixteen operations with both flag policies. These runs tell the logical carry path from the adder carry path, and they show when the flag pass-through applies. Directed operands sit on the signed and unsigned wrap points: 0x7FFFFFFF+1, 0−1, equal operands, and all-ones plus carry. These separate the V rule from the C rule and check the no-borrow meaning of C in the forward, reverse and carry-based subtractions. Program-counter cases with and without a register-specified shift separate the +8 look-ahead from the +12 look-ahead. Idle cycles confirm that the write strobe drops.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    // Test-only group: flags change, destination untouched
    function automatic logic op_is_test(alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    // Operations routed through the adder
    function automatic logic op_is_arith(alu_op_e op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                           OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int DATA_W    = 32,
    parameter int PC_AHEAD  = 8,
    parameter int REG_EXTRA = 4
) (
    input  logic [DATA_W-1:0] operand_a,
    input  logic              op_a_is_pc,
    input  logic              shift_by_reg,
    input  logic [DATA_W-1:0] inst_addr,
    output logic [DATA_W-1:0] op_a_eff
);
    localparam logic [DATA_W-1:0] AHEAD_NORM = DATA_W'(PC_AHEAD);
    localparam logic [DATA_W-1:0] AHEAD_REG  = DATA_W'(PC_AHEAD + REG_EXTRA);

    always_comb begin
        if (op_a_is_pc) begin
            op_a_eff = inst_addr + (shift_by_reg ? AHEAD_REG : AHEAD_NORM);
        end else begin
            op_a_eff = operand_a;
        end
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in_flag,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out,
    output logic              overflow
);
    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_ci;
    logic [DATA_W:0]   wide;

    // Subtraction = x + ~y + carry; reverse forms swap the inverted side
    always_comb begin
        add_x  = op_a;
        add_y  = op_b;
        add_ci = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin add_x = op_a; add_y = ~op_b; add_ci = 1'b1;          end
            OP_RSB:         begin add_x = op_b; add_y = ~op_a; add_ci = 1'b1;          end
            OP_ADD, OP_CMN: begin add_x = op_a; add_y = op_b;  add_ci = 1'b0;          end
            OP_ADC:         begin add_x = op_a; add_y = op_b;  add_ci = carry_in_flag; end
            OP_SBC:         begin add_x = op_a; add_y = ~op_b; add_ci = carry_in_flag; end
            OP_RSC:         begin add_x = op_b; add_y = ~op_a; add_ci = carry_in_flag; end
            default:        begin add_x = op_a; add_y = op_b;  add_ci = 1'b0;          end
        endcase
    end

    always_comb begin
        wide      = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};
        sum       = wide[DATA_W-1:0];
        carry_out = wide[DATA_W];
        overflow  = (add_x[DATA_W-1] == add_y[DATA_W-1]) &&
                    (sum[DATA_W-1] != add_x[DATA_W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] bit_res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: bit_res = op_a & op_b;
            OP_EOR, OP_TEQ: bit_res = op_a ^ op_b;
            OP_ORR:         bit_res = op_a | op_b;
            OP_MOV:         bit_res = op_b;
            OP_BIC:         bit_res = op_a & ~op_b;
            OP_MVN:         bit_res = ~op_b;
            default:        bit_res = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PC_AHEAD  = 8,
    parameter int REG_EXTRA = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] operand_a,
    input  logic [DATA_W-1:0] operand_b,
    input  logic              op_a_is_pc,
    input  logic              shift_by_reg,
    input  logic [DATA_W-1:0] inst_addr,
    input  logic              shift_carry,
    input  logic              flag_n_in,
    input  logic              flag_z_in,
    input  logic              flag_c_in,
    input  logic              flag_v_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        alu_flags_t        fl;
    } stage_t;

    alu_op_e           op;
    logic [DATA_W-1:0] op_a_eff;
    logic [DATA_W-1:0] add_sum;
    logic              add_co;
    logic              add_ov;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] res_sel;
    stage_t            st_d;
    stage_t            st_q;

    assign op = alu_op_e'(opcode);

    alu_operand_sel #(
        .DATA_W   (DATA_W),
        .PC_AHEAD (PC_AHEAD),
        .REG_EXTRA(REG_EXTRA)
    ) i_sel (
        .operand_a   (operand_a),
        .op_a_is_pc  (op_a_is_pc),
        .shift_by_reg(shift_by_reg),
        .inst_addr   (inst_addr),
        .op_a_eff    (op_a_eff)
    );

    alu_adder #(.DATA_W(DATA_W)) i_add (
        .op           (op),
        .op_a         (op_a_eff),
        .op_b         (operand_b),
        .carry_in_flag(flag_c_in),
        .sum          (add_sum),
        .carry_out    (add_co),
        .overflow     (add_ov)
    );

    alu_logic #(.DATA_W(DATA_W)) i_log (
        .op     (op),
        .op_a   (op_a_eff),
        .op_b   (operand_b),
        .bit_res(bit_res)
    );

    assign res_sel = op_is_arith(op) ? add_sum : bit_res;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (op_valid) begin
            st_d.res = res_sel;
            st_d.we  = !op_is_test(op);
            if (set_flags) begin
                st_d.fl.n = res_sel[DATA_W-1];
                st_d.fl.z = (res_sel == '0);
                st_d.fl.c = op_is_arith(op) ? add_co : shift_carry;
                st_d.fl.v = op_is_arith(op) ? add_ov : flag_v_in;
            end else begin
                st_d.fl = '{n: flag_n_in, z: flag_z_in, c: flag_c_in, v: flag_v_in};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign result_we = st_q.we;
    assign flag_n    = st_q.fl.n;
    assign flag_z    = st_q.fl.z;
    assign flag_c    = st_q.fl.c;
    assign flag_v    = st_q.fl.v;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic [DATA_W-1:0] operand_b,
    input logic              op_a_is_pc,
    input logic              shift_carry,
    input logic              flag_n_in,
    input logic              flag_z_in,
    input logic              flag_c_in,
    input logic              flag_v_in,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);
    logic is_test_op;
    logic is_logic_op;

    assign is_test_op  = (opcode[3:2] == 2'b10);
    assign is_logic_op = (opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_test_op) |=> !result_we); // R4
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !result_we); // R4
    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && is_logic_op) |=> (flag_c == $past(shift_carry))); // R6
    AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && is_logic_op) |=> (flag_v == $past(flag_v_in))); // R6
    AST_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !set_flags) |=>
        ({flag_n, flag_z, flag_c, flag_v} ==
         $past({flag_n_in, flag_z_in, flag_c_in, flag_v_in}))); // R8
    AST_N_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags) |=> (flag_n == result[DATA_W-1])); // R7
    AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags) |=> (flag_z == (result == '0))); // R7
    AST_MOV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 4'hD) |=> (result == $past(operand_b))); // R1
    AST_WRITE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_test_op && !op_a_is_pc) |=> result_we); // R4
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .set_flags  (set_flags),
    .operand_b  (operand_b),
    .op_a_is_pc (op_a_is_pc),
    .shift_carry(shift_carry),
    .flag_n_in  (flag_n_in),
    .flag_z_in  (flag_z_in),
    .flag_c_in  (flag_c_in),
    .flag_v_in  (flag_v_in),
    .result     (result),
    .result_we  (result_we),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .flag_v     (flag_v)
);

// File: tb/test_alu_core.sv
module test_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] operand_a = '0;
    logic [31:0] operand_b = '0;
    logic        op_a_is_pc = 1'b0;
    logic        shift_by_reg = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        shift_carry = 1'b0;
    logic        flag_n_in = 1'b0, flag_z_in = 1'b0, flag_c_in = 1'b0, flag_v_in = 1'b0;
    logic [31:0] result;
    logic        result_we, flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_core i_alu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .set_flags(set_flags), .operand_a(operand_a), .operand_b(operand_b),
        .op_a_is_pc(op_a_is_pc), .shift_by_reg(shift_by_reg), .inst_addr(inst_addr),
        .shift_carry(shift_carry), .flag_n_in(flag_n_in), .flag_z_in(flag_z_in),
        .flag_c_in(flag_c_in), .flag_v_in(flag_v_in), .result(result),
        .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: {res[31:0], we, n, z, c, v}
    function automatic logic [36:0] model(logic [3:0] op, logic s, logic [31:0] a,
        logic [31:0] b, logic sc, logic n, logic z, logic c, logic v);
        logic [31:0] r, x, y;
        logic        co, ov, arith, is_sub;
        logic [33:0] wx, wy;
        logic [33:0] kin;
        longint      sv;
        arith  = 1'b1; is_sub = 1'b0; x = a; y = b; kin = 34'd0;
        r = '0; co = 1'b0; ov = 1'b0;
        case (op)
            4'h0, 4'h8: begin r = a & b;  arith = 1'b0; end
            4'h1, 4'h9: begin r = a ^ b;  arith = 1'b0; end
            4'hC:       begin r = a | b;  arith = 1'b0; end
            4'hD:       begin r = b;      arith = 1'b0; end
            4'hE:       begin r = a & ~b; arith = 1'b0; end
            4'hF:       begin r = ~b;     arith = 1'b0; end
            4'h2, 4'hA: begin is_sub = 1'b1; kin = 34'd0; end
            4'h3:       begin is_sub = 1'b1; x = b; y = a; kin = 34'd0; end
            4'h4, 4'hB: begin kin = 34'd0; end
            4'h5:       begin kin = {33'd0, c}; end
            4'h6:       begin is_sub = 1'b1; kin = {33'd0, !c}; end
            4'h7:       begin is_sub = 1'b1; x = b; y = a; kin = {33'd0, !c}; end
            default: ;
        endcase
        if (arith) begin
            wx = {2'b00, x};
            wy = {2'b00, y};
            if (is_sub) begin
                r  = x - y - kin[31:0];
                co = (wx >= wy + kin);
                sv = longint'($signed(x)) - longint'($signed(y)) - longint'(kin);
            end else begin
                r  = x + y + kin[31:0];
                co = ((wx + wy + kin) > 34'h0FFFFFFFF);
                sv = longint'($signed(x)) + longint'($signed(y)) + longint'(kin);
            end
            ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        end
        if (s) return {r, !(op[3:2] == 2'b10), r[31], (r == 0), arith ? co : sc, arith ? ov : v};
        return {r, !(op[3:2] == 2'b10), n, z, c, v};
    endfunction

    function automatic string res_tag(logic [3:0] op, logic pc);
        if (pc) return "R9";
        if (op inside {4'h5, 4'h6, 4'h7}) return "R3";
        if (op inside {4'h2, 4'h3, 4'h4, 4'hA, 4'hB}) return "R2";
        return "R1";
    endfunction

    task automatic run_op(logic [3:0] op, logic s, logic [31:0] a, logic [31:0] b,
                          logic sc, logic [3:0] fin, logic pc, logic sbr, logic [31:0] ia);
        logic [36:0] e;
        logic [31:0] a_eff;
        logic        arith;
        opcode = op; set_flags = s; operand_a = a; operand_b = b; shift_carry = sc;
        {flag_n_in, flag_z_in, flag_c_in, flag_v_in} = fin;
        op_a_is_pc = pc; shift_by_reg = sbr; inst_addr = ia; op_valid = 1'b1;
        a_eff = pc ? (ia + (sbr ? 32'd12 : 32'd8)) : a;
        e = model(op, s, a_eff, b, sc, fin[3], fin[2], fin[1], fin[0]);
        arith = op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};
        @(negedge clk);
        check({res_tag(op, pc), " result"}, 64'(result), 64'(e[36:5]));
        check("R4 write strobe", 64'(result_we), 64'(e[4]));
        check(s ? "R7 N/Z" : "R8 N/Z pass", 64'({flag_n, flag_z}), 64'(e[3:2]));
        check(!s ? "R8 C/V pass" : (arith ? "R5 C/V" : "R6 C/V"),
              64'({flag_c, flag_v}), 64'(e[1:0]));
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", 64'({result, result_we, flag_n, flag_z, flag_c, flag_v}), 64'd0);
        rst_n = 1'b1;
        // Directed corners
        run_op(4'h4, 1, 32'h7FFFFFFF, 32'h1, 0, 4'h0, 0, 0, 0);        // R5 V on add
        run_op(4'h2, 1, 32'h0, 32'h1, 0, 4'h0, 0, 0, 0);               // R5 borrow: C=0
        run_op(4'hA, 1, 32'h55, 32'h55, 0, 4'h0, 0, 0, 0);             // R7 Z, R4 no write
        run_op(4'h5, 1, 32'hFFFFFFFF, 32'h0, 0, 4'h2, 0, 0, 0);        // R3 ADC carry out
        run_op(4'h6, 1, 32'h10, 32'h3, 0, 4'h0, 0, 0, 0);              // R3 SBC C=0
        run_op(4'h7, 1, 32'h3, 32'h10, 0, 4'h2, 0, 0, 0);              // R3 RSC C=1
        run_op(4'h3, 1, 32'h80000000, 32'h1, 0, 4'h0, 0, 0, 0);        // R2 RSB overflow
        run_op(4'hB, 1, 32'hFFFFFFFF, 32'h1, 0, 4'h0, 0, 0, 0);        // R4 CMN no write
        run_op(4'hE, 1, 32'hF0F0F0F0, 32'hFF00FF00, 1, 4'h1, 0, 0, 0); // R6 BIC C from shifter, V kept
        run_op(4'hF, 0, 32'h0, 32'h12345678, 1, 4'hA, 0, 0, 0);        // R8 flags pass
        run_op(4'h4, 0, 32'h0, 32'h4, 0, 4'h5, 1, 0, 32'h1000);        // R9 +8
        run_op(4'h4, 0, 32'h0, 32'h4, 0, 4'h5, 1, 1, 32'h1000);        // R9 +12
        // Idle cycle: R4 strobe drops
        op_valid = 1'b0;
        @(negedge clk);
        check("R4 idle strobe", 64'(result_we), 64'd0);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom), 1'($urandom), $urandom, $urandom, 1'($urandom),
                   4'($urandom), ($urandom % 8) == 0, 1'($urandom), $urandom);
        end
        op_valid = 1'b0;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule